// File: doc/BRIEF.md
# Disk-Port Phase State Decoder

This block sits behind the floppy-style port of a directly attached disk device. The host uses three of its four phase lines as a state bus rather than as register selects. The block synchronises those lines and decodes them into one of eight protocol states. For each state it reports a host-active flag, a holdoff flag and a low-active handshake. It also drives the single read-return line: a fixed identification level, the handshake level, or the serial transmit bit from the codec, depending on the state. Code 1 is the communication state and code 0 is the suspend (holdoff) state.

Several such devices can share one port, and a plain floppy drive may sit at the end of the chain. The fourth phase line carries a pulse that tells the currently selected device to pass selection downstream. The device then releases the return line and raises its downstream enable. It stays that way until its own enable input is dropped. Each time the decoded state code changes, the protocol engine gets a one-cycle strobe along with the new code.

Top module: `chain_phase_decoder`

## Requirements
- R1: While reset is asserted, and after it with idle inputs, the outputs read: state_code 0, state_changed 0, rd_oe 0, rd_out 1, chain_en_out 0, host_flag 1, hoff_flag 1, hshk_n 1.
- R2: The flags follow the registered code. host_flag is 1 only for codes 0 and 1. hoff_flag is 1 only for codes 0 and 3. hshk_n is the inverse of dev_ready.
- R3: In the identification codes, rd_out carries a fixed level while the device is selected: code 4 gives 1, code 5 gives 0, code 6 gives 1.
- R4: In code 1, rd_out follows tx_serial one clock after tx_serial is sampled.
- R5: In codes 0, 2, 3 and 7, rd_out shows the handshake level, which is the inverse of dev_ready.
- R6: A change on ph_lines or sel_in reaches state_code, the flags, rd_out and rd_oe on the third rising clock edge after the change.
- R7: state_changed is high for one cycle, together with the new state_code, exactly when the decoded code differs from the previous one.
- R8: While the device is not selected, rd_oe is 0 and rd_out is held at 1.
- R9: While selected, a falling edge on ph_chain completes a chain pulse. It drops rd_oe and raises chain_en_out on the third rising edge after the fall. Further pulses have no effect on the outputs while sel_in stays high.
- R10: When sel_in goes low, the pass-on state clears, so chain_en_out returns to 0. When sel_in rises again, the device is selected and rd_oe returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ph_lines | input | 3 | Asynchronous phase lines forming the state code |
| ph_chain | input | 1 | Asynchronous fourth phase line carrying chain pulses |
| sel_in | input | 1 | Asynchronous enable from the port or the upstream device |
| dev_ready | input | 1 | Device-ready level from the protocol engine |
| tx_serial | input | 1 | Serial transmit bit from the codec |
| rd_out | output | 1 | Read-return line value |
| rd_oe | output | 1 | Output enable for the return line |
| chain_en_out | output | 1 | Enable for the downstream device |
| state_code | output | 3 | Registered protocol state code |
| state_changed | output | 1 | One-cycle strobe on a state change |
| host_flag | output | 1 | Host-active flag of the current state |
| hoff_flag | output | 1 | Holdoff flag of the current state |
| hshk_n | output | 1 | Low-active handshake |

## Verification
A wrongly decoded or stale state code shows up on rd_out and the flags at the third edge after the phase change. In the identification codes this gives a wrong fixed level, which the host would read as a floppy drive. A pass-on register that is set wrongly releases rd_oe, or fails to release it, and raises chain_en_out at that same third edge. A strobe that misfires appears either as a pulse with an unchanged code or as a code change with no pulse, within one cycle.

// File: rtl/cpd_pkg.sv
// Package: shared constants and the state attribute table for the phase decoder.
// Assumes a 3-bit state code; every code maps to exactly one attribute set.
package cpd_pkg;

    localparam int PH_W          = 3;
    localparam int NUM_STATES    = 1 << PH_W;
    localparam logic [PH_W-1:0] ST_SUSPEND = 3'd0;
    localparam logic [PH_W-1:0] ST_COMM    = 3'd1;

    // What the return line carries in a given state
    typedef enum logic [1:0] {
        ROLE_TX   = 2'd0,
        ROLE_HSHK = 2'd1,
        ROLE_HIGH = 2'd2,
        ROLE_LOW  = 2'd3
    } rd_role_e;

    typedef struct packed {
        logic     host;
        logic     hoff;
        rd_role_e role;
    } state_attr_t;

    // Attribute lookup for one state code
    function automatic state_attr_t attr_of(input logic [PH_W-1:0] code);
        state_attr_t a;
        case (code)
            3'd0:    a = '{host: 1'b1, hoff: 1'b1, role: ROLE_HSHK};
            3'd1:    a = '{host: 1'b1, hoff: 1'b0, role: ROLE_TX};
            3'd2:    a = '{host: 1'b0, hoff: 1'b0, role: ROLE_HSHK};
            3'd3:    a = '{host: 1'b0, hoff: 1'b1, role: ROLE_HSHK};
            3'd4:    a = '{host: 1'b0, hoff: 1'b0, role: ROLE_HIGH};
            3'd5:    a = '{host: 1'b0, hoff: 1'b0, role: ROLE_LOW};
            3'd6:    a = '{host: 1'b0, hoff: 1'b0, role: ROLE_HIGH};
            default: a = '{host: 1'b0, hoff: 1'b0, role: ROLE_HSHK};
        endcase
        return a;
    endfunction

endpackage

// File: rtl/cpd_sync.sv
// Multi-bit flop-chain synchroniser. Each bit is independent.
// Assumes the inputs are quasi-static levels. Stages sit at reset value 0 under reset.
module cpd_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // One synchroniser stage
            always_ff @(posedge clk) begin
                if (!rst_n)      stage_q[s] <= '0;
                else if (s == 0) stage_q[s] <= d_async;
                else             stage_q[s] <= stage_q[(s > 0) ? s - 1 : 0];
            end
        end
    endgenerate

    assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/cpd_chain_sel.sv
// Daisy-chain selection: tracks whether this device still owns the port.
// Assumes synchronised inputs. A chain pulse counts at its falling edge.
module cpd_chain_sel (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_s,
    input  logic chain_s,
    output logic own_sel_d,
    output logic rd_oe_q,
    output logic chain_en_q
);
    logic chain_prev_q;
    logic passed_q;
    logic passed_d;
    logic chain_fall;

    assign chain_fall = chain_prev_q & ~chain_s;

    // Next pass-on state: cleared without enable, set by a pulse while owning
    always_comb begin
        if (!sel_s)                      passed_d = 1'b0;
        else if (chain_fall && !passed_q) passed_d = 1'b1;
        else                              passed_d = passed_q;
    end

    assign own_sel_d = sel_s & ~passed_d;

    // Register pass-on state, edge history and the chain outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_prev_q <= 1'b0;
            passed_q     <= 1'b0;
            rd_oe_q      <= 1'b0;
            chain_en_q   <= 1'b0;
        end else begin
            chain_prev_q <= chain_s;
            passed_q     <= passed_d;
            rd_oe_q      <= own_sel_d;
            chain_en_q   <= sel_s & passed_d;
        end
    end
endmodule

// File: rtl/cpd_state_decode.sv
// State decode: registers the code, its flags and a change strobe.
// Assumes a synchronised code input. dev_ready is already in the clock domain.
module cpd_state_decode
    import cpd_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PH_W-1:0] code_s,
    input  logic            dev_ready,
    output logic [PH_W-1:0] state_q,
    output logic            changed_q,
    output logic            host_q,
    output logic            hoff_q,
    output logic            hshk_n_q
);
    state_attr_t attr;

    assign attr = attr_of(code_s);

    // Capture the state, its flags and the change strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_SUSPEND;
            changed_q <= 1'b0;
            host_q    <= 1'b1;
            hoff_q    <= 1'b1;
            hshk_n_q  <= 1'b1;
        end else begin
            state_q   <= code_s;
            changed_q <= (code_s != state_q);
            host_q    <= attr.host;
            hoff_q    <= attr.hoff;
            hshk_n_q  <= ~dev_ready;
        end
    end
endmodule

// File: rtl/cpd_rd_mux.sv
// Return-line multiplexer: picks the identification level, the handshake or the tx bit.
// Assumes own_sel_d is the next-cycle ownership. The line idles high when released.
module cpd_rd_mux
    import cpd_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PH_W-1:0] code_s,
    input  logic            own_sel_d,
    input  logic            tx_serial,
    input  logic            dev_ready,
    output logic            rd_q
);
    state_attr_t attr;
    logic        rd_d;

    assign attr = attr_of(code_s);

    // Select the return value by the role of the state
    always_comb begin
        if (!own_sel_d) rd_d = 1'b1;
        else begin
            case (attr.role)
                ROLE_TX:   rd_d = tx_serial;
                ROLE_HIGH: rd_d = 1'b1;
                ROLE_LOW:  rd_d = 1'b0;
                default:   rd_d = ~dev_ready;
            endcase
        end
    end

    // Register the return line
    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= 1'b1;
        else        rd_q <= rd_d;
    end
endmodule

// File: rtl/chain_phase_decoder.sv
// Top: synchronises the phase and enable lines, decodes the protocol state,
// drives the return line and handles daisy-chain hand-over.
// Assumes asynchronous port inputs. Latency from a port change to the outputs is
// SYNC_STAGES + 1 clocks.
module chain_phase_decoder
    import cpd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PH_W-1:0] ph_lines,
    input  logic            ph_chain,
    input  logic            sel_in,
    input  logic            dev_ready,
    input  logic            tx_serial,
    output logic            rd_out,
    output logic            rd_oe,
    output logic            chain_en_out,
    output logic [PH_W-1:0] state_code,
    output logic            state_changed,
    output logic            host_flag,
    output logic            hoff_flag,
    output logic            hshk_n
);
    localparam int SYNC_W = PH_W + 2;

    logic [SYNC_W-1:0] raw_in;
    logic [SYNC_W-1:0] syn;
    logic [PH_W-1:0]   code_s;
    logic              chain_s;
    logic              sel_s;
    logic              own_sel_d;

    assign raw_in  = {sel_in, ph_chain, ph_lines};
    assign code_s  = syn[PH_W-1:0];
    assign chain_s = syn[PH_W];
    assign sel_s   = syn[PH_W+1];

    cpd_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (raw_in),
        .q_sync  (syn)
    );

    cpd_chain_sel i_chain (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_s      (sel_s),
        .chain_s    (chain_s),
        .own_sel_d  (own_sel_d),
        .rd_oe_q    (rd_oe),
        .chain_en_q (chain_en_out)
    );

    cpd_state_decode i_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .code_s    (code_s),
        .dev_ready (dev_ready),
        .state_q   (state_code),
        .changed_q (state_changed),
        .host_q    (host_flag),
        .hoff_q    (hoff_flag),
        .hshk_n_q  (hshk_n)
    );

    cpd_rd_mux i_mux (
        .clk       (clk),
        .rst_n     (rst_n),
        .code_s    (code_s),
        .own_sel_d (own_sel_d),
        .tx_serial (tx_serial),
        .dev_ready (dev_ready),
        .rd_q      (rd_out)
    );
endmodule

// File: rtl/cpd_checker.sv
// Checker: temporal properties of the decoder outputs, bound to the top.
module cpd_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_serial,
    input logic       rd_out,
    input logic       rd_oe,
    input logic       chain_en_out,
    input logic [2:0] state_code,
    input logic       state_changed,
    input logic       host_flag,
    input logic       hoff_flag
);
    AST_STROBE_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        state_changed |-> (state_code != $past(state_code))); // R7
    AST_NO_SILENT_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !state_changed |-> $stable(state_code)); // R7
    AST_OWNER_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_oe && chain_en_out)); // R9
    AST_RELEASED_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_oe |-> rd_out); // R8
    AST_COMM_FOLLOWS_TX: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_oe && state_code == 3'd1 && $past(rst_n)) |-> (rd_out == $past(tx_serial))); // R4
    AST_ID_LOW_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_oe && state_code == 3'd5) |-> !rd_out); // R3
    AST_HOST_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        host_flag |-> (state_code == 3'd0 || state_code == 3'd1)); // R2
    AST_HOFF_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        hoff_flag |-> (state_code == 3'd0 || state_code == 3'd3)); // R2
endmodule

bind chain_phase_decoder cpd_checker i_cpd_checker (.*);

// File: tb/test_chain_phase_decoder.sv
// Scoreboard bench: driver tasks push expected items, a monitor pops and compares.
module test_chain_phase_decoder;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] ph_lines = 3'd0;
    logic       ph_chain = 1'b0;
    logic       sel_in = 1'b0;
    logic       dev_ready = 1'b0;
    logic       tx_serial = 1'b0;
    logic       rd_out, rd_oe, chain_en_out, state_changed, host_flag, hoff_flag, hshk_n;
    logic [2:0] state_code;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [8:0] vec;   // {rd, oe, chain, code[2:0], strobe, host, hoff} plus hshk_n below
        logic       hs;
        string      tag;
    } exp_t;
    exp_t q[$];

    // Model state derived from the requirements
    logic [2:0] m_last = 3'd0;
    logic       m_p3 = 1'b0;
    logic       m_pass = 1'b0;
    logic       m_strobe = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    chain_phase_decoder i_chain_phase_decoder (
        .clk(clk), .rst_n(rst_n), .ph_lines(ph_lines), .ph_chain(ph_chain),
        .sel_in(sel_in), .dev_ready(dev_ready), .tx_serial(tx_serial),
        .rd_out(rd_out), .rd_oe(rd_oe), .chain_en_out(chain_en_out),
        .state_code(state_code), .state_changed(state_changed),
        .host_flag(host_flag), .hoff_flag(hoff_flag), .hshk_n(hshk_n)
    );

    // Expected return level for a code while selected (R3, R4, R5)
    function automatic logic exp_rd(input logic [2:0] c);
        case (c)
            3'd1:          return tx_serial;
            3'd4, 3'd6:    return 1'b1;
            3'd5:          return 1'b0;
            default:       return ~dev_ready;
        endcase
    endfunction

    function automatic void push_exp(input string tag);
        exp_t e;
        logic own;
        own = sel_in & ~m_pass;
        e.vec = {own ? exp_rd(m_last) : 1'b1, own, sel_in & m_pass, m_last, m_strobe,
                 (m_last == 3'd0 || m_last == 3'd1), (m_last == 3'd0 || m_last == 3'd3)};
        e.hs  = ~dev_ready;
        e.tag = tag;
        q.push_back(e);
    endfunction

    // Drive all port inputs, wait the synchroniser and decode latency, push expectation (R6)
    task automatic apply(input logic [2:0] ph, input logic p3, input logic s,
                         input logic rdy, input logic tx, input string tag);
        @(negedge clk);
        ph_lines = ph; ph_chain = p3; sel_in = s; dev_ready = rdy; tx_serial = tx;
        if (!s) m_pass = 1'b0;
        else if (m_p3 && !p3 && !m_pass) m_pass = 1'b1;
        m_p3 = p3;
        m_strobe = (ph != m_last);
        m_last = ph;
        repeat (3) @(posedge clk);
        push_exp(tag);
        m_strobe = 1'b0;
    endtask

    // Monitor: pop and compare at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0) begin
                exp_t e;
                logic [8:0] act;
                e = q.pop_front();
                act = {rd_out, rd_oe, chain_en_out, state_code, state_changed, host_flag, hoff_flag};
                checks++;
                if (act !== e.vec || hshk_n !== e.hs) begin
                    fails++;
                    $display("FAIL %s: actual %b/%b expected %b/%b", e.tag, act, hshk_n, e.vec, e.hs);
                end
            end
        end
    end

    // Watchdog
    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        push_exp("R1 reset state");
        @(negedge clk);
        rst_n = 1'b1;
        apply(3'd0, 0, 0, 0, 0, "R1 idle after reset");
        apply(3'd0, 0, 1, 1, 0, "R8 R10 selected suspend, R5 handshake ready");
        apply(3'd0, 0, 1, 0, 0, "R5 suspend handshake not ready, R2 flags");
        apply(3'd4, 0, 1, 0, 0, "R3 R6 R7 id code 4 high");
        apply(3'd5, 0, 1, 0, 0, "R3 id code 5 low");
        apply(3'd6, 0, 1, 1, 0, "R3 id code 6 high");
        apply(3'd6, 0, 1, 1, 0, "R7 no strobe on same code");
        apply(3'd3, 0, 1, 1, 0, "R2 R5 code 3 holdoff flag");
        apply(3'd2, 0, 1, 0, 0, "R2 R5 code 2");
        apply(3'd7, 0, 1, 1, 0, "R5 code 7");
        apply(3'd1, 0, 1, 1, 1, "R4 comm tx high");
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            tx_serial = i[0];
            @(posedge clk);
            push_exp("R4 comm tx per cycle");
        end
        apply(3'd5, 0, 0, 0, 0, "R8 deselected id state released");
        apply(3'd5, 0, 1, 0, 0, "R10 reselected");
        apply(3'd5, 1, 1, 0, 0, "R9 chain pulse high, still owner");
        apply(3'd5, 0, 1, 0, 0, "R9 chain pulse fall passes on");
        apply(3'd1, 0, 1, 0, 1, "R9 R8 passed comm stays released");
        apply(3'd1, 1, 1, 0, 1, "R9 second pulse high ignored");
        apply(3'd1, 0, 1, 0, 1, "R9 second pulse fall ignored");
        apply(3'd1, 0, 0, 0, 1, "R10 enable low clears pass");
        apply(3'd0, 0, 1, 1, 1, "R10 owner again in suspend");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule